// File: doc/BRIEF.md
# Receive Descriptor Ring Dispatcher

This block fans receive descriptors out from one shared input ring into several target rings. Each target ring belongs to exactly one destination, such as a processing core. A producer writes fixed-width descriptor words into the input ring. The dispatcher takes the oldest one and offers it to an external classifier. When the classifier answers with a destination index, the dispatcher copies the descriptor word unchanged into that destination's ring. It then retires the word from the input ring and signals the destination with an interrupt pulse. Only the descriptor word moves. Any buffer pointer or metadata it carries passes through as opaque bits, and packet payload never enters the block.

Each destination drains its own ring through a dedicated pop port. Nothing is ever dropped. When the chosen target ring is full, the dispatcher holds that descriptor and leaves the input ring untouched until the consumer makes room. Interrupts are sent either immediately, one per forwarded descriptor, or through a moderation timer that raises at most one pulse per destination per timer window. A flush request stops new input, forwards everything still queued, releases any held interrupts and then reports completion.

Top module: `rx_desc_dispatch`

## Requirements
- R1: After reset, `in_ready` is 1, every bit of `tgt_empty` is 1, and `irq`, `cls_req` and `flush_done` are 0.
- R2: A descriptor accepted at the input appears unaltered at the head of the target ring whose index the classifier returned on `cls_dest`, and no other target ring receives it.
- R3: Descriptors sent to the same target ring leave it through its pop port in the order they entered the input ring.
- R4: When the selected target ring is full, the dispatcher stalls. The input ring is not advanced, no later descriptor reaches any ring, and dispatch resumes once the consumer pops an entry.
- R5: With `mod_en` low, each forwarded descriptor produces exactly one single-cycle `irq` pulse on its own destination bit.
- R6: With `mod_en` high, a timer counts cycles from the cycle `mod_en` goes high, and a window closes every MOD_TICKS cycles. No interrupt is raised per copy. When a window closes, each destination that received at least one descriptor in that window gets one pulse, and the other destinations get none.
- R7: A one-cycle `flush` pulse drops `in_ready` on the next cycle. Once the input ring is empty and the dispatcher is idle, `flush_done` pulses once. In that same cycle, any moderated interrupt still held is released, and `in_ready` returns to 1 afterwards.
- R8: When the input ring holds IN_DEPTH descriptors, `in_ready` is 0, and a descriptor offered while `in_ready` is 0 is discarded and never reaches a target ring.
- R9: A pop request on an empty target ring has no effect. A descriptor dispatched afterwards is the only entry in that ring.
- R10: While `cls_req` is high and `cls_ack` is low, `cls_req` stays high and `cls_desc` holds the oldest input descriptor unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Producer offers a descriptor |
| in_desc | input | DESC_W | Descriptor word offered to the input ring |
| in_ready | output | 1 | Input ring accepts a descriptor this cycle |
| cls_req | output | 1 | Classification request for the oldest input descriptor |
| cls_desc | output | DESC_W | Descriptor presented to the classifier |
| cls_ack | input | 1 | Classifier answer valid |
| cls_dest | input | DEST_W | Destination index chosen by the classifier |
| tgt_pop | input | N_DEST | Per-destination pop request |
| tgt_desc | output | N_DEST*DESC_W | Head descriptor of each target ring, destination d in slice d |
| tgt_empty | output | N_DEST | Per-destination ring empty flag |
| irq | output | N_DEST | Per-destination interrupt pulse |
| mod_en | input | 1 | Selects timer-moderated interrupts |
| flush | input | 1 | Request to drain the input ring |
| flush_done | output | 1 | One-cycle pulse when the drain is complete |

## Verification
The assertions assume that the classifier keeps `cls_dest` inside 0 to N_DEST-1 whenever it raises `cls_ack`. They also assume that the block's own gating keeps pushes off full rings, so an overflow assertion firing means a fault in the dispatch sequencer, not misuse by the caller. The bench classifier derives the destination from the two low bits of each descriptor, so every answer is in range. It can also hold back its acknowledge to open a window in which the request must stay steady. Moderation and flush tests switch `mod_en` at known cycles, so that window boundaries fall where the expected pulse counts are computed.

// File: rtl/rdd_pkg.sv
package rdd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_CLASSIFY = 2'd1,
    ST_WRITE    = 2'd2
  } disp_state_e;
endpackage

// File: rtl/rdd_ring.sv
// Power-of-two ring with wrap-bit pointers; head word readable without popping.
module rdd_ring #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head_data,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);

  logic [AW:0]  wr_ptr_q, wr_ptr_d;
  logic [AW:0]  rd_ptr_q, rd_ptr_d;
  logic [W-1:0] mem_q [DEPTH];
  logic         push_ok, pop_ok;

  assign empty = (wr_ptr_q == rd_ptr_q);
  assign full  = (wr_ptr_q[AW] != rd_ptr_q[AW]) &&
                 (wr_ptr_q[AW-1:0] == rd_ptr_q[AW-1:0]);

  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    if (push_ok) wr_ptr_d = wr_ptr_q + 1'b1;
    if (pop_ok)  rd_ptr_d = rd_ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem_q[wr_ptr_q[AW-1:0]] <= push_data;
  end

  assign head_data = mem_q[rd_ptr_q[AW-1:0]];

  // R4: the dispatcher must never push into a full ring (stall instead of drop)
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // R3: the oldest entry stays put until it is popped
  assert_head_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && !pop) |=> (!empty && $stable(head_data)));
endmodule

// File: rtl/rdd_ctrl.sv
// Dispatch sequencer: offer head to classifier, then copy into chosen ring.
module rdd_ctrl
  import rdd_pkg::*;
#(
  parameter int N_DEST = 4,
  parameter int DESC_W = 32,
  localparam int DEST_W = $clog2(N_DEST)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_empty,
  input  logic [DESC_W-1:0] in_head,
  input  logic              cls_ack,
  input  logic [DEST_W-1:0] cls_dest,
  input  logic [N_DEST-1:0] tgt_full,
  output logic              cls_req,
  output logic [DESC_W-1:0] cls_desc,
  output logic              in_pop,
  output logic [N_DEST-1:0] tgt_push,
  output logic [DESC_W-1:0] tgt_wdata,
  output logic              idle
);
  disp_state_e       state_q, state_d;
  logic [DEST_W-1:0] dest_q, dest_d;
  logic              dest_en;
  logic              room;

  assign room      = !tgt_full[dest_q];
  assign cls_req   = (state_q == ST_CLASSIFY);
  assign cls_desc  = in_head;
  assign tgt_wdata = in_head;
  assign idle      = (state_q == ST_IDLE);
  assign in_pop    = (state_q == ST_WRITE) && room;

  always_comb begin
    for (int d = 0; d < N_DEST; d++) begin
      tgt_push[d] = (state_q == ST_WRITE) && (dest_q == DEST_W'(d)) && room;
    end
  end

  always_comb begin
    state_d = state_q;
    dest_en = 1'b0;
    dest_d  = cls_dest;
    unique case (state_q)
      ST_IDLE:     if (!in_empty) state_d = ST_CLASSIFY;
      ST_CLASSIFY: if (cls_ack) begin
                     dest_en = 1'b1;
                     state_d = ST_WRITE;
                   end
      ST_WRITE:    if (room) state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      dest_q  <= '0;
    end else begin
      state_q <= state_d;
      if (dest_en) dest_q <= dest_d;
    end
  end

  // R10: an unanswered request keeps the same descriptor on offer
  assert_cls_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_req && !cls_ack) |=> (cls_req && $stable(cls_desc)));

  // R2: a copy lands in at most one target ring
  assert_single_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tgt_push));

  // R4: retiring an input entry only happens together with a target write
  assert_retire_with_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_pop |-> ($countones(tgt_push) == 1));
endmodule

// File: rtl/rdd_irq.sv
// Per-destination interrupt generation, direct or timer-moderated.
module rdd_irq #(
  parameter int N_DEST    = 4,
  parameter int MOD_TICKS = 16,
  localparam int TW = $clog2(MOD_TICKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mod_en,
  input  logic [N_DEST-1:0] push,
  input  logic              release_all,
  output logic [N_DEST-1:0] irq
);
  logic [TW-1:0]     timer_q, timer_d;
  logic              tick, fire;
  logic [N_DEST-1:0] pend_q, pend_d;
  logic [N_DEST-1:0] irq_q, irq_d;

  assign tick = mod_en && (timer_q == TW'(MOD_TICKS - 1));
  assign fire = tick || release_all || !mod_en;

  always_comb begin
    if (!mod_en || tick) timer_d = '0;
    else                 timer_d = timer_q + 1'b1;
  end

  for (genvar d = 0; d < N_DEST; d++) begin : g_dest
    always_comb begin
      irq_d[d]  = fire && (pend_q[d] || push[d]);
      pend_d[d] = fire ? 1'b0 : (pend_q[d] || push[d]);
    end

    // R5: without moderation every copy is signalled on the next cycle
    assert_direct_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!mod_en && push[d]) |=> irq[d]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timer_q <= '0;
      pend_q  <= '0;
      irq_q   <= '0;
    end else begin
      timer_q <= timer_d;
      pend_q  <= pend_d;
      irq_q   <= irq_d;
    end
  end

  assign irq = irq_q;

  // R6: a moderated pulse never appears in the middle of a window
  assert_mod_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && !tick && !release_all) |=> (irq == '0));
endmodule

// File: rtl/rx_desc_dispatch.sv
module rx_desc_dispatch #(
  parameter int N_DEST    = 4,
  parameter int DESC_W    = 32,
  parameter int IN_DEPTH  = 8,
  parameter int TGT_DEPTH = 4,
  parameter int MOD_TICKS = 16,
  localparam int DEST_W = $clog2(N_DEST)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [DESC_W-1:0]        in_desc,
  output logic                     in_ready,
  output logic                     cls_req,
  output logic [DESC_W-1:0]        cls_desc,
  input  logic                     cls_ack,
  input  logic [DEST_W-1:0]        cls_dest,
  input  logic [N_DEST-1:0]        tgt_pop,
  output logic [N_DEST*DESC_W-1:0] tgt_desc,
  output logic [N_DEST-1:0]        tgt_empty,
  output logic [N_DEST-1:0]        irq,
  input  logic                     mod_en,
  input  logic                     flush,
  output logic                     flush_done
);
  logic              in_full, in_empty, in_pop, in_push;
  logic [DESC_W-1:0] in_head;
  logic [N_DEST-1:0] tgt_full, tgt_push;
  logic [DESC_W-1:0] tgt_wdata;
  logic              ctrl_idle;
  logic              flushing_q, flushing_d;
  logic              done_q, done_d;

  assign in_ready = !in_full && !flushing_q;
  assign in_push  = in_valid && in_ready;

  rdd_ring #(.W(DESC_W), .DEPTH(IN_DEPTH)) u_in_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (in_push),
    .push_data (in_desc),
    .pop       (in_pop),
    .head_data (in_head),
    .full      (in_full),
    .empty     (in_empty)
  );

  rdd_ctrl #(.N_DEST(N_DEST), .DESC_W(DESC_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_empty  (in_empty),
    .in_head   (in_head),
    .cls_ack   (cls_ack),
    .cls_dest  (cls_dest),
    .tgt_full  (tgt_full),
    .cls_req   (cls_req),
    .cls_desc  (cls_desc),
    .in_pop    (in_pop),
    .tgt_push  (tgt_push),
    .tgt_wdata (tgt_wdata),
    .idle      (ctrl_idle)
  );

  for (genvar d = 0; d < N_DEST; d++) begin : g_tgt
    rdd_ring #(.W(DESC_W), .DEPTH(TGT_DEPTH)) u_tgt_ring (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (tgt_push[d]),
      .push_data (tgt_wdata),
      .pop       (tgt_pop[d]),
      .head_data (tgt_desc[d*DESC_W +: DESC_W]),
      .full      (tgt_full[d]),
      .empty     (tgt_empty[d])
    );
  end

  always_comb begin
    done_d     = flushing_q && in_empty && ctrl_idle;
    flushing_d = (flushing_q && !done_d) || flush;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flushing_q <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      flushing_q <= flushing_d;
      done_q     <= done_d;
    end
  end

  assign flush_done = done_q;

  rdd_irq #(.N_DEST(N_DEST), .MOD_TICKS(MOD_TICKS)) u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .mod_en      (mod_en),
    .push        (tgt_push),
    .release_all (done_d),
    .irq         (irq)
  );

  // R7: completion is only reported with nothing left in the input ring
  assert_flush_drained_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |-> (in_empty && !cls_req));

  // R8: the input ring is never written beyond capacity
  assert_in_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_full |=> !$rose(in_empty));
endmodule

// File: tb/rx_desc_dispatch_tb_top.sv
module rx_desc_dispatch_tb_top;
  localparam int ND = 4;
  localparam int DW = 32;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           in_valid;
  logic [DW-1:0]  in_desc;
  logic           in_ready;
  logic           cls_req;
  logic [DW-1:0]  cls_desc;
  logic           cls_ack;
  logic [1:0]     cls_dest;
  logic [ND-1:0]  tgt_pop;
  logic [ND*DW-1:0] tgt_desc;
  logic [ND-1:0]  tgt_empty;
  logic [ND-1:0]  irq;
  logic           mod_en;
  logic           flush;
  logic           flush_done;

  int n_cmp = 0;
  int n_err = 0;
  int irq_cnt [ND];
  logic cls_hold;

  always #2 clk = ~clk;

  rx_desc_dispatch dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_desc(in_desc),
    .in_ready(in_ready), .cls_req(cls_req), .cls_desc(cls_desc),
    .cls_ack(cls_ack), .cls_dest(cls_dest), .tgt_pop(tgt_pop),
    .tgt_desc(tgt_desc), .tgt_empty(tgt_empty), .irq(irq),
    .mod_en(mod_en), .flush(flush), .flush_done(flush_done)
  );

  // classifier model: destination = two low bits of the descriptor
  initial begin
    cls_ack = 1'b0;
    cls_dest = '0;
    forever begin
      @(negedge clk);
      if (cls_req && !cls_hold) begin
        cls_ack = 1'b1;
        cls_dest = cls_desc[1:0];
      end else begin
        cls_ack = 1'b0;
      end
    end
  end

  initial begin
    for (int d = 0; d < ND; d++) irq_cnt[d] = 0;
    forever begin
      @(negedge clk);
      for (int d = 0; d < ND; d++) if (irq[d]) irq_cnt[d]++;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_desc(input logic [DW-1:0] d);
    in_valid = 1'b1;
    in_desc = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pop_chk(input int dest, input logic [DW-1:0] exp, input string req);
    chk(req, tgt_empty[dest], 1'b0);
    chk(req, tgt_desc[dest*DW +: DW], exp);
    tgt_pop[dest] = 1'b1;
    @(negedge clk);
    tgt_pop[dest] = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 in_ready", in_ready, 1'b1);
    chk("R1 tgt_empty", tgt_empty, 4'hF);
    chk("R1 irq", irq, 4'h0);
    chk("R1 cls_req", cls_req, 1'b0);
    chk("R1 flush_done", flush_done, 1'b0);
  endtask

  task automatic t_basic;
    int base [ND];
    for (int d = 0; d < ND; d++) base[d] = irq_cnt[d];
    for (int d = 0; d < ND; d++) push_desc(32'hA000_0000 | (d << 8) | d);
    wait_cyc(24);
    for (int d = 0; d < ND; d++) begin
      chk("R5 one irq per copy", irq_cnt[d] - base[d], 1);
      pop_chk(d, 32'hA000_0000 | (d << 8) | d, "R2 routed descriptor");
    end
    chk("R2 rings empty after pop", tgt_empty, 4'hF);
  endtask

  task automatic t_order;
    for (int i = 0; i < 3; i++) push_desc(32'h5500_0002 | (i << 4));
    wait_cyc(20);
    for (int i = 0; i < 3; i++) pop_chk(2, 32'h5500_0002 | (i << 4), "R3 order");
    chk("R3 ring2 empty", tgt_empty[2], 1'b1);
  endtask

  task automatic t_stall;
    int base1;
    base1 = irq_cnt[1];
    for (int i = 0; i < 5; i++) push_desc(32'h1000_0001 | (i << 4));
    wait_cyc(30);
    chk("R4 stalled, no request", cls_req, 1'b0);
    push_desc(32'h2000_0000);
    wait_cyc(12);
    chk("R4 later descriptor held", tgt_empty[0], 1'b1);
    pop_chk(1, 32'h1000_0001, "R4 first");
    wait_cyc(12);
    chk("R4 resumed", tgt_empty[0], 1'b0);
    for (int i = 1; i < 5; i++) pop_chk(1, 32'h1000_0001 | (i << 4), "R4 no drop");
    chk("R4 ring1 drained", tgt_empty[1], 1'b1);
    pop_chk(0, 32'h2000_0000, "R4 after stall");
    chk("R5 five pulses", irq_cnt[1] - base1, 5);
  endtask

  task automatic t_input_full;
    cls_hold = 1'b1;
    for (int i = 0; i < 8; i++) push_desc(32'h3000_0000 | (i << 4) | (i % 4));
    chk("R8 in_ready low when full", in_ready, 1'b0);
    chk("R10 request raised", cls_req, 1'b1);
    chk("R10 oldest offered", cls_desc, 32'h3000_0000);
    push_desc(32'h3000_0080);
    wait_cyc(3);
    chk("R10 request held", cls_req, 1'b1);
    chk("R10 descriptor stable", cls_desc, 32'h3000_0000);
    cls_hold = 1'b0;
    wait_cyc(50);
    for (int d = 0; d < ND; d++) begin
      pop_chk(d, 32'h3000_0000 | (d << 4) | d, "R8 kept entry");
      pop_chk(d, 32'h3000_0000 | ((d + 4) << 4) | d, "R8 kept entry");
    end
    chk("R8 rejected descriptor absent", tgt_empty, 4'hF);
  endtask

  task automatic t_pop_empty;
    tgt_pop[2] = 1'b1;
    @(negedge clk);
    tgt_pop[2] = 1'b0;
    push_desc(32'h7700_0006);
    wait_cyc(12);
    pop_chk(2, 32'h7700_0006, "R9 pop on empty ignored");
    chk("R9 single entry", tgt_empty[2], 1'b1);
  endtask

  task automatic t_moderation;
    int base [ND];
    for (int d = 0; d < ND; d++) base[d] = irq_cnt[d];
    mod_en = 1'b1;
    push_desc(32'h4400_0000);
    push_desc(32'h4400_0012);
    push_desc(32'h4400_0020);
    wait_cyc(7);
    chk("R6 no per-copy irq d0", irq_cnt[0] - base[0], 0);
    chk("R6 no per-copy irq d2", irq_cnt[2] - base[2], 0);
    wait_cyc(10);
    chk("R6 one pulse d0", irq_cnt[0] - base[0], 1);
    chk("R6 one pulse d2", irq_cnt[2] - base[2], 1);
    chk("R6 none d1", irq_cnt[1] - base[1], 0);
    chk("R6 none d3", irq_cnt[3] - base[3], 0);
    mod_en = 1'b0;
    pop_chk(0, 32'h4400_0000, "R6 data");
    pop_chk(0, 32'h4400_0020, "R6 data");
    pop_chk(2, 32'h4400_0012, "R6 data");
  endtask

  task automatic t_flush;
    int dones;
    int base3;
    dones = 0;
    base3 = irq_cnt[3];
    mod_en = 1'b1;
    push_desc(32'h6600_0003);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    chk("R7 in_ready low while flushing", in_ready, 1'b0);
    for (int i = 0; i < 30; i++) begin
      if (flush_done) begin
        dones++;
        chk("R7 held irq released with done", irq[3], 1'b1);
      end
      @(negedge clk);
    end
    mod_en = 1'b0;
    chk("R7 single done pulse", dones, 1);
    chk("R7 one irq d3", irq_cnt[3] - base3, 1);
    chk("R7 in_ready restored", in_ready, 1'b1);
    pop_chk(3, 32'h6600_0003, "R7 drained into ring");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_desc = '0;
    tgt_pop = '0;
    mod_en = 1'b0;
    flush = 1'b0;
    cls_hold = 1'b0;
    wait_cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_basic;
    t_order;
    t_stall;
    t_input_full;
    t_pop_empty;
    t_moderation;
    wait_cyc(5);
    t_flush;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule